// File: doc/BRIEF.md
# SDR SDRAM Command Legality Monitor

A passive observer for the command bus of a four-bank single-data-rate SDRAM. On every rising clock edge it decodes the command from the chip-select, row-strobe, column-strobe and write-enable pins. It tracks the state of each bank: idle, open, closing, or writing with automatic close. It also tracks whether the device is refreshing. The rule set is applied to each command against the addressed bank and against all the other banks. A command is flagged if it does not fit the current state or arrives before a minimum spacing has elapsed.

A flagged command produces a one-cycle error pulse in the following cycle, together with a reason code and a bank number. A flagged command is treated as if it never happened, so the tracked state does not change. The monitor drives nothing onto the memory bus. It is meant to sit beside a memory controller in simulation or on silicon as a protocol watchdog. All spacings are parameters in clock cycles, and every timer saturates.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: After reset all banks are idle, the device is not refreshing, and the error outputs are low and zero. An ACTV to any bank is legal as the first command.
- R2: Commands are decoded from {cs_n, ras_n, cas_n, we_n} as follows: 1xxx deselect, 0111 no-op, 0101 READ, 0100 WRIT, 0011 ACTV, 0010 PRE (a10=1 means all banks), 0001 REF, 0000 MRS. Deselect and no-op are never flagged.
- R3: A READ or WRIT to a bank that is not open gives code 2 (not open).
- R4: A READ or WRIT issued fewer than TRCD cycles after the accepted ACTV to that bank gives code 3. At exactly TRCD cycles it is legal.
- R5: An ACTV to a bank that is still closing gives code 4 if fewer than TRP cycles have passed since the close began. At exactly TRP cycles it is legal. A READ with a10=1 starts a close.
- R6: An ACTV to an open bank gives code 5 (bank busy). So does a READ, WRIT, PRE or ACTV to a bank that is writing with automatic close. Other banks stay usable while that write runs.
- R7: An ACTV fewer than TRRD cycles after the previous accepted ACTV, to any bank, gives code 6.
- R8: A PRE to an open bank, or a PRE with a10=1 while any open bank qualifies, gives code 7 if fewer than BURST_LEN-1+TDPL cycles have passed since that bank's last WRIT. For the all-banks form, the reported bank is the lowest offending bank.
- R9: REF or MRS while any bank is not idle gives code 8 and reports the lowest non-idle bank.
- R10: While a refresh is running (fewer than TRC cycles since the accepted REF), any command other than deselect or no-op gives code 1 and reports its bank-address pins. This check has the highest priority.
- R11: A PRE with a10=1 while any bank is writing with automatic close gives code 5 for the lowest such bank. A PRE of either form to an idle bank has no effect.
- R12: The error pulse, code and bank appear in the cycle after the command. The pulse is high exactly when the code is non-zero. A flagged command leaves all tracked state unchanged.
- R13: A WRIT with a10=1 closes its bank by itself BURST_LEN-1+TDPL cycles after the write. The bank may be reopened TRP cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-close select for READ/WRIT; all-banks select for PRE |
| err_pulse | output | 1 | One-cycle flag for an illegal command |
| err_code | output | 4 | Reason code, 0 when no error |
| err_bank | output | BA_W | Bank the error concerns |

## Verification
The bench builds the monitor with TRCD=2, TRP=2, TRRD=2, TRC=4, TDPL=1 and BURST_LEN=4. With these values every spacing limit can be hit one cycle early and then exactly on time within a short script. The write-with-close window is four cycles long. That is long enough to probe the busy bank, use a neighbouring bank, and attempt a refresh before the bank closes by itself. The short refresh window lets both the early rejection and the first legal command after it be observed.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

    typedef enum logic [2:0] {
        C_DESL, C_NOP, C_READ, C_WRIT, C_ACTV, C_PRE, C_REF, C_MRS
    } cmd_e;

    typedef enum logic [1:0] {
        B_IDLE, B_OPEN, B_CLOSING, B_WRAP
    } bank_st_e;

    typedef enum logic [3:0] {
        E_NONE     = 4'd0,
        E_REF_BUSY = 4'd1,
        E_NOT_OPEN = 4'd2,
        E_TRCD     = 4'd3,
        E_TRP      = 4'd4,
        E_BUSY     = 4'd5,
        E_TRRD     = 4'd6,
        E_TDPL     = 4'd7,
        E_NOT_IDLE = 4'd8
    } err_e;

    // What the rule engine needs to know about one bank
    typedef struct packed {
        logic idle;          // idle, or closing with TRP met
        logic open;          // row open
        logic wrap;          // write with automatic close in flight
        logic closing_early; // closing and TRP not yet met
        logic rcd_ok;        // TRCD met since ACTV
        logic dpl_ok;        // write-to-close spacing met
    } bank_view_t;

    function automatic cmd_e decode(input logic cs_n, input logic ras_n,
                                    input logic cas_n, input logic we_n);
        if (cs_n) return C_DESL;
        case ({ras_n, cas_n, we_n})
            3'b101:  return C_READ;
            3'b100:  return C_WRIT;
            3'b011:  return C_ACTV;
            3'b010:  return C_PRE;
            3'b001:  return C_REF;
            3'b000:  return C_MRS;
            default: return C_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdr_mon_bank.sv
module sdr_mon_bank
    import sdr_mon_pkg::*;
#(
    parameter int CW       = 6,
    parameter int TRCD     = 3,
    parameter int TRP      = 3,
    parameter int WAP_DONE = 5,
    parameter int DPL_MIN  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_e       cmd,
    input  logic       hit,
    input  logic       a10,
    input  logic       accept,
    output bank_view_t view
);
    localparam logic [CW-1:0] CMAX   = '1;
    localparam logic [CW-1:0] TRCD_C = CW'(TRCD);
    localparam logic [CW-1:0] TRP_C  = CW'(TRP);
    localparam logic [CW-1:0] WAP_C  = CW'(WAP_DONE);
    localparam logic [CW-1:0] DPL_C  = CW'(DPL_MIN);

    bank_st_e        st;
    logic [CW-1:0]   cnt;   // cycles since entering the current state
    logic [CW-1:0]   wcnt;  // cycles since the last plain write

    always_comb begin
        view.idle          = (st == B_IDLE) || (st == B_CLOSING && cnt >= TRP_C);
        view.open          = (st == B_OPEN);
        view.wrap          = (st == B_WRAP);
        view.closing_early = (st == B_CLOSING) && (cnt < TRP_C);
        view.rcd_ok        = (cnt >= TRCD_C);
        view.dpl_ok        = (wcnt >= DPL_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= B_IDLE;
            cnt  <= CMAX;
            wcnt <= CMAX;
        end else begin
            if (cnt != CMAX)  cnt  <= cnt + 1'b1;
            if (wcnt != CMAX) wcnt <= wcnt + 1'b1;
            case (st)
                B_CLOSING: if (cnt >= TRP_C) st <= B_IDLE;
                B_WRAP:    if (cnt >= WAP_C) begin
                               st  <= B_CLOSING;
                               cnt <= CW'(1);
                           end
                default: ;
            endcase
            if (accept) begin
                if (hit && cmd == C_ACTV) begin
                    st   <= B_OPEN;
                    cnt  <= CW'(1);
                    wcnt <= CMAX;
                end else if (hit && cmd == C_READ && a10) begin
                    st  <= B_CLOSING;
                    cnt <= CW'(1);
                end else if (hit && cmd == C_WRIT) begin
                    if (a10) begin
                        st  <= B_WRAP;
                        cnt <= CW'(1);
                    end else begin
                        wcnt <= CW'(1);
                    end
                end else if (cmd == C_PRE && (hit || a10) && st == B_OPEN) begin
                    st  <= B_CLOSING;
                    cnt <= CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sdr_mon_dev.sv
module sdr_mon_dev
    import sdr_mon_pkg::*;
#(
    parameter int CW   = 6,
    parameter int TRC  = 10,
    parameter int TRRD = 2
) (
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd,
    input  logic accept,
    output logic ref_busy,
    output logic rrd_ok
);
    localparam logic [CW-1:0] CMAX   = '1;
    localparam logic [CW-1:0] TRC_C  = CW'(TRC);
    localparam logic [CW-1:0] TRRD_C = CW'(TRRD);

    logic          refreshing;
    logic [CW-1:0] rc_cnt;
    logic [CW-1:0] rrd_cnt;

    assign ref_busy = refreshing && (rc_cnt < TRC_C);
    assign rrd_ok   = (rrd_cnt >= TRRD_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            refreshing <= 1'b0;
            rc_cnt     <= CMAX;
            rrd_cnt    <= CMAX;
        end else begin
            if (rc_cnt != CMAX)  rc_cnt  <= rc_cnt + 1'b1;
            if (rrd_cnt != CMAX) rrd_cnt <= rrd_cnt + 1'b1;
            if (refreshing && rc_cnt >= TRC_C) refreshing <= 1'b0;
            if (accept && cmd == C_REF) begin
                refreshing <= 1'b1;
                rc_cnt     <= CW'(1);
            end
            if (accept && cmd == C_ACTV) rrd_cnt <= CW'(1);
        end
    end
endmodule

// File: rtl/sdr_mon_judge.sv
module sdr_mon_judge
    import sdr_mon_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  cmd_e                  cmd,
    input  logic [BW-1:0]         ba,
    input  logic                  a10,
    input  bank_view_t [NB-1:0]   views,
    input  logic                  ref_busy,
    input  logic                  rrd_ok,
    output err_e                  code,
    output logic [BW-1:0]         bank
);
    bank_view_t    tgt;
    logic          any_wrap, any_dpl, any_busy;
    logic [BW-1:0] wrap_idx, dpl_idx, busy_idx;

    always_comb begin
        tgt      = views[ba];
        any_wrap = 1'b0;
        any_dpl  = 1'b0;
        any_busy = 1'b0;
        wrap_idx = '0;
        dpl_idx  = '0;
        busy_idx = '0;
        // walk downward so the lowest index wins
        for (int i = NB - 1; i >= 0; i--) begin
            if (views[i].wrap) begin
                any_wrap = 1'b1;
                wrap_idx = BW'(i);
            end
            if (views[i].open && !views[i].dpl_ok) begin
                any_dpl = 1'b1;
                dpl_idx = BW'(i);
            end
            if (!views[i].idle) begin
                any_busy = 1'b1;
                busy_idx = BW'(i);
            end
        end

        code = E_NONE;
        bank = ba;
        if (cmd != C_DESL && cmd != C_NOP && ref_busy) begin
            code = E_REF_BUSY;
        end else begin
            case (cmd)
                C_READ, C_WRIT: begin
                    if (tgt.wrap)         code = E_BUSY;
                    else if (!tgt.open)   code = E_NOT_OPEN;
                    else if (!tgt.rcd_ok) code = E_TRCD;
                end
                C_ACTV: begin
                    if (tgt.open || tgt.wrap) code = E_BUSY;
                    else if (tgt.closing_early) code = E_TRP;
                    else if (!rrd_ok)     code = E_TRRD;
                end
                C_PRE: begin
                    if (a10) begin
                        if (any_wrap) begin
                            code = E_BUSY;
                            bank = wrap_idx;
                        end else if (any_dpl) begin
                            code = E_TDPL;
                            bank = dpl_idx;
                        end
                    end else begin
                        if (tgt.wrap) code = E_BUSY;
                        else if (tgt.open && !tgt.dpl_ok) code = E_TDPL;
                    end
                end
                C_REF, C_MRS: begin
                    if (any_busy) begin
                        code = E_NOT_IDLE;
                        bank = busy_idx;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
    import sdr_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    parameter int TRP       = 3,
    parameter int TRRD      = 2,
    parameter int TRC       = 10,
    parameter int TDPL      = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            err_pulse,
    output logic [3:0]      err_code,
    output logic [BA_W-1:0] err_bank
);
    localparam int DPL_MIN = BURST_LEN - 1 + TDPL;
    localparam int CW = $clog2(TRC + TRCD + TRP + TRRD + TDPL + BURST_LEN + 2) + 1;

    cmd_e                       cmd;
    bank_view_t [NUM_BANKS-1:0] views;
    logic                       ref_busy, rrd_ok, accept;
    err_e                       code;
    logic [BA_W-1:0]            code_bank;

    assign cmd    = decode(cs_n, ras_n, cas_n, we_n);
    assign accept = (code == E_NONE);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdr_mon_bank #(
            .CW(CW), .TRCD(TRCD), .TRP(TRP),
            .WAP_DONE(DPL_MIN), .DPL_MIN(DPL_MIN)
        ) u_bank (
            .clk(clk), .rst(rst), .cmd(cmd),
            .hit(ba == BA_W'(g)), .a10(a10), .accept(accept),
            .view(views[g])
        );
    end

    sdr_mon_dev #(.CW(CW), .TRC(TRC), .TRRD(TRRD)) u_dev (
        .clk(clk), .rst(rst), .cmd(cmd), .accept(accept),
        .ref_busy(ref_busy), .rrd_ok(rrd_ok)
    );

    sdr_mon_judge #(.NB(NUM_BANKS), .BW(BA_W)) u_judge (
        .cmd(cmd), .ba(ba), .a10(a10), .views(views),
        .ref_busy(ref_busy), .rrd_ok(rrd_ok),
        .code(code), .bank(code_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse <= 1'b0;
            err_code  <= 4'd0;
            err_bank  <= '0;
        end else begin
            err_pulse <= !accept;
            err_code  <= code;
            err_bank  <= accept ? '0 : code_bank;
        end
    end
endmodule

// File: rtl/sdr_mon_chk.sv
module sdr_mon_chk
    import sdr_mon_pkg::*;
#(
    parameter int TRCD = 3,
    parameter int TRC  = 10,
    parameter int BA_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [BA_W-1:0] ba,
    input logic            err_pulse,
    input logic [3:0]      err_code
);
    cmd_e c;
    assign c = decode(cs_n, ras_n, cas_n, we_n);

    // R12
    pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse == (err_code != 4'd0));

    // R2
    quiet_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (c == C_DESL || c == C_NOP) |=> !err_pulse);

    // R4
    early_read_chk: assert property (@(posedge clk) disable iff (rst)
        (TRCD > 1 && c == C_ACTV) ##1 (c == C_READ && ba == $past(ba) && !err_pulse)
        |=> err_pulse);

    // R10
    double_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (TRC > 1 && c == C_REF) ##1 (c == C_REF && !err_pulse)
        |=> (err_pulse && err_code == 4'd1));
endmodule

bind sdr_cmd_monitor sdr_mon_chk #(.TRCD(TRCD), .TRC(TRC), .BA_W(BA_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/sdr_cmd_monitor_tb.sv
module sdr_cmd_monitor_tb;
    localparam logic [3:0] P_DESL = 4'b1111, P_NOP = 4'b0111, P_READ = 4'b0101,
                           P_WRIT = 4'b0100, P_ACTV = 4'b0011, P_PRE = 4'b0010,
                           P_REF = 4'b0001, P_MRS = 4'b0000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic       err_pulse;
    logic [3:0] err_code;
    logic [1:0] err_bank;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int         cyc;
        logic [3:0] code;
        logic [1:0] bank;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdr_cmd_monitor #(
        .NUM_BANKS(4), .TRCD(2), .TRP(2), .TRRD(2),
        .TRC(4), .TDPL(1), .BURST_LEN(4)
    ) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10),
        .err_pulse(err_pulse), .err_code(err_code), .err_bank(err_bank)
    );

    task automatic issue(input logic [3:0] pins, input logic [1:0] b, input logic a,
                         input logic [3:0] ecode, input logic [1:0] ebank, input string tag);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba  = b;
        a10 = a;
        q.push_back('{cyc, ecode, ebank, tag});
    endtask

    // monitor: checks each command one cycle after it was sampled
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].cyc < cyc) begin
                exp_t it;
                it = q.pop_front();
                n_tests++;
                if (err_pulse !== (it.code != 4'd0) || err_code !== it.code ||
                    (it.code != 4'd0 && err_bank !== it.bank)) begin
                    n_fail++;
                    $display("FAIL %s: pulse=%0b code=%0d bank=%0d expected code=%0d bank=%0d",
                             it.tag, err_pulse, err_code, err_bank, it.code, it.bank);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_tests++;
        if (err_pulse !== 1'b0 || err_code !== 4'd0) begin
            n_fail++;
            $display("FAIL R1 reset: pulse=%0b code=%0d expected 0/0", err_pulse, err_code);
        end
        issue(P_DESL, 2'd0, 1'b0, 4'd0, 2'd0, "R2 deselect");
        issue(P_PRE,  2'd2, 1'b0, 4'd0, 2'd0, "R11 pre idle bank");
        issue(P_ACTV, 2'd0, 1'b0, 4'd0, 2'd0, "R1 first actv");
        issue(P_READ, 2'd0, 1'b0, 4'd3, 2'd0, "R4 read early");
        issue(P_READ, 2'd0, 1'b0, 4'd0, 2'd0, "R4 read on time");
        issue(P_READ, 2'd1, 1'b0, 4'd2, 2'd1, "R3 read closed");
        issue(P_WRIT, 2'd2, 1'b0, 4'd2, 2'd2, "R3 write closed");
        issue(P_ACTV, 2'd1, 1'b0, 4'd0, 2'd0, "R7 actv spaced");
        issue(P_ACTV, 2'd2, 1'b0, 4'd6, 2'd2, "R7 actv too close");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_ACTV, 2'd2, 1'b0, 4'd0, 2'd0, "R12 rejected actv left bank idle");
        issue(P_ACTV, 2'd0, 1'b0, 4'd5, 2'd0, "R6 actv open bank");
        issue(P_WRIT, 2'd1, 1'b0, 4'd0, 2'd0, "R8 plain write");
        issue(P_PRE,  2'd1, 1'b0, 4'd7, 2'd1, "R8 pre after write early");
        issue(P_PRE,  2'd0, 1'b1, 4'd7, 2'd1, "R8 pall after write early");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_PRE,  2'd1, 1'b0, 4'd0, 2'd0, "R8 pre on time");
        issue(P_ACTV, 2'd1, 1'b0, 4'd4, 2'd1, "R5 actv while closing");
        issue(P_ACTV, 2'd1, 1'b0, 4'd0, 2'd0, "R5 actv at trp");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_ACTV, 2'd3, 1'b0, 4'd0, 2'd0, "R7 actv at trrd");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_WRIT, 2'd3, 1'b1, 4'd0, 2'd0, "R13 write auto close");
        issue(P_READ, 2'd3, 1'b0, 4'd5, 2'd3, "R6 read busy bank");
        issue(P_READ, 2'd0, 1'b0, 4'd0, 2'd0, "R6 read other bank");
        issue(P_PRE,  2'd3, 1'b0, 4'd5, 2'd3, "R6 pre busy bank");
        issue(P_REF,  2'd0, 1'b0, 4'd8, 2'd0, "R9 ref with open banks");
        issue(P_ACTV, 2'd3, 1'b0, 4'd4, 2'd3, "R13 actv during auto close");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_PRE,  2'd0, 1'b1, 4'd0, 2'd0, "R8 pall legal");
        issue(P_MRS,  2'd0, 1'b0, 4'd8, 2'd0, "R9 mrs while closing");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_REF,  2'd0, 1'b0, 4'd0, 2'd0, "R9 ref all idle");
        issue(P_READ, 2'd0, 1'b0, 4'd1, 2'd0, "R10 read in refresh");
        issue(P_ACTV, 2'd2, 1'b0, 4'd1, 2'd2, "R10 actv in refresh");
        issue(P_PRE,  2'd0, 1'b1, 4'd1, 2'd0, "R10 pall in refresh");
        issue(P_MRS,  2'd0, 1'b0, 4'd0, 2'd0, "R10 mrs after trc");
        issue(P_PRE,  2'd1, 1'b1, 4'd0, 2'd0, "R11 pall all idle");
        issue(P_ACTV, 2'd0, 1'b0, 4'd0, 2'd0, "R1 actv");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_WRIT, 2'd0, 1'b1, 4'd0, 2'd0, "R13 write auto close");
        issue(P_PRE,  2'd2, 1'b1, 4'd5, 2'd0, "R11 pall with busy bank");
        issue(P_ACTV, 2'd0, 1'b0, 4'd5, 2'd0, "R6 actv busy bank");
        issue(P_WRIT, 2'd1, 1'b0, 4'd2, 2'd1, "R3 write closed");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_ACTV, 2'd0, 1'b0, 4'd0, 2'd0, "R13 reopen after close");
        issue(P_READ, 2'd0, 1'b1, 4'd3, 2'd0, "R4 read early");
        issue(P_READ, 2'd0, 1'b1, 4'd0, 2'd0, "R5 read auto close");
        issue(P_ACTV, 2'd0, 1'b0, 4'd4, 2'd0, "R5 actv after read close");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        issue(P_NOP,  2'd0, 1'b0, 4'd0, 2'd0, "R2 nop");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule